// File: doc/BRIEF.md
# Serial Audio Link Frame Engine

This block runs the bit-serial side of a stereo audio codec link. On every rising edge of the link bit clock it drives the frame marker (`sync`) and the outgoing data line. On every falling edge it captures the incoming data line. Each frame is 256 bit times long. It opens with a 16-bit tag slot, and twelve 20-bit data slots follow it. Frames are sent back to back.

The outgoing frame can carry one pending codec register command (address and, for a write, data) and one left and one right playback sample. Each item is taken from a valid/taken handshake that the frame engine samples at the frame boundary. The incoming frame is decoded when its last bit arrives. The decode yields the codec-ready flag, a returned register status word, left and right record samples, and the per-channel sample requests used in variable-rate mode. In fixed-rate mode a playback sample goes out in every frame that has one pending. In variable-rate mode a sample goes out only when the previous incoming frame asked for it.

A power-down input stops the link and clears the decoded state. When the input is released, a fresh frame starts. The block sits entirely in the bit-clock domain. Register decoding and sample queues belong to the surrounding logic.

Top module: `aclink_frame_engine`

## Requirements
- R1: Once running, `sync` is high for bit times 0 to 15 of each 256-bit frame and low for bit times 16 to 255, and the next frame starts on the bit time straight after bit 255. The first frame starts on the first rising edge after reset is released.
- R2: `sync` and `sdata_out` change only on rising edges of `bit_clk`. `sdata_in` is captured on the falling edge of `bit_clk`, so any change of `sdata_in` after that falling edge does not affect the frame.
- R3: Outgoing bits are sent MSB first, the tag slot first and then slots 1 to 12. Tag bit 15 is set when any slot is valid. Tag bits 14, 13, 12 and 11 mark slots 1, 2, 3 and 4 as valid. All other tag bits and all invalid or unused slots are zero.
- R4: With `cmd_valid` high at a frame boundary, slot 1 carries {`cmd_rd`, `cmd_addr`[6:0], 12 zero bits}. For a write (`cmd_rd`=0), slot 2 carries {`cmd_data`, 4 zero bits} and is tagged valid. For a read, slot 2 is zero and untagged. `cmd_taken` pulses for one cycle in bit time 0 of that frame.
- R5: In fixed-rate mode (`vra_en`=0), every frame that starts while `play_l_valid` (or `play_r_valid`) is high carries that sample in slot 3 (or slot 4), and `play_l_taken` (or `play_r_taken`) pulses in bit time 0.
- R6: In variable-rate mode (`vra_en`=1), a pending left (right) sample is sent only if bit 11 (bit 10) of slot 1 of the incoming frame that has just ended is set. The first frame after reset or power-down carries no sample.
- R7: At the end of each incoming frame, `codec_ready` takes the value of incoming tag bit 15.
- R8: When incoming tag bits 14 and 13 are both set, `sts_valid` pulses for one cycle at frame end, with `sts_addr` equal to slot 1 bits 18:12 and `sts_data` equal to slot 2 bits 19:4. Otherwise `sts_valid` stays low.
- R9: Incoming tag bit 12 (bit 11) makes `rec_l_valid` (`rec_r_valid`) pulse for one cycle at frame end, with `rec_l` (`rec_r`) equal to slot 3 (slot 4). An untagged slot raises no pulse even when the slot holds data.
- R10: While `pwr_down` is high, `sync` and `sdata_out` are low, `codec_ready` is 0 and no taken pulse occurs. On the first rising edge after release a new frame starts.
- R11: During reset, `sync`, `sdata_out`, `codec_ready` and every pulse output are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Stops link activity while high |
| vra_en | input | 1 | 1 = variable-rate playback, 0 = fixed rate |
| cmd_valid | input | 1 | A register command is pending |
| cmd_rd | input | 1 | Command is a read (1) or a write (0) |
| cmd_addr | input | 7 | Codec register address |
| cmd_data | input | 16 | Codec register write data |
| cmd_taken | output | 1 | Command placed in the current frame |
| play_l_valid | input | 1 | Left playback sample pending |
| play_l | input | 20 | Left playback sample |
| play_l_taken | output | 1 | Left sample placed in the current frame |
| play_r_valid | input | 1 | Right playback sample pending |
| play_r | input | 20 | Right playback sample |
| play_r_taken | output | 1 | Right sample placed in the current frame |
| sync | output | 1 | Frame marker |
| sdata_out | output | 1 | Serial data towards the codec |
| sdata_in | input | 1 | Serial data from the codec |
| codec_ready | output | 1 | Codec-ready flag from the last frame |
| sts_valid | output | 1 | Register status returned, one-cycle pulse |
| sts_addr | output | 7 | Returned register address |
| sts_data | output | 16 | Returned register data |
| rec_l_valid | output | 1 | Left record sample received, one-cycle pulse |
| rec_l | output | 20 | Left record sample |
| rec_r_valid | output | 1 | Right record sample received, one-cycle pulse |
| rec_r | output | 20 | Right record sample |

## Verification
On every cycle the assertions check the following:
- the frame wrap and the 16-bit marker length;
- that power-down silences the link and clears the ready flag;
- that taken, status and record strobes last a single cycle;
- that a taken pulse always coincides with a set frame-valid bit on the wire;
- that a variable-rate sample never leaves without a request.

Only the bench's scenarios can show the bit-exact slot contents, the falling-edge capture and the one-frame lag of variable-rate requests. The bench shows capture by corrupting the data line after each falling edge and comparing whole 256-bit frames against frames it builds independently. The same scenarios show that untagged incoming slots are ignored.

// File: rtl/aclink_pkg.sv
`timescale 1ns/1ps
package aclink_pkg;

    localparam int TAG_BITS      = 16;
    localparam int SLOT_BITS     = 20;
    localparam int DATA_SLOTS    = 12;
    localparam int CMD_ADDR_BITS = 7;
    localparam int CMD_DATA_BITS = 16;

    // total bit times in one frame
    function automatic int frame_len(input int tag_w, input int slot_w, input int nslot);
        return tag_w + slot_w * nslot;
    endfunction

    // index of the first (most significant) bit of data slot n, n counted from 1
    function automatic int slot_top(input int tag_w, input int slot_w, input int nslot, input int n);
        return frame_len(tag_w, slot_w, nslot) - 1 - tag_w - slot_w * (n - 1);
    endfunction

    // tag bit for slot n; n = 0 is the frame-valid / codec-ready bit
    function automatic int tag_pos(input int tag_w, input int n);
        return tag_w - 1 - n;
    endfunction

endpackage

// File: rtl/aclink_timing.sv
`timescale 1ns/1ps
module aclink_timing #(
    parameter int TAG_W   = aclink_pkg::TAG_BITS,
    parameter int FRAME_W = 256
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic pwr_down,
    output logic sync,
    output logic active,
    output logic frame_load,
    output logic frame_end
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(TAG_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             sync;
    } tim_t;

    tim_t tim_d, tim_q;

    always_comb begin
        frame_end  = tim_q.active && (tim_q.cnt == LAST_BIT);
        frame_load = !pwr_down && (!tim_q.active || frame_end);
        tim_d      = tim_q;
        if (pwr_down) begin
            tim_d = '0;
        end else if (frame_load) begin
            tim_d.cnt    = '0;
            tim_d.active = 1'b1;
            tim_d.sync   = 1'b1;
        end else begin
            tim_d.cnt  = tim_q.cnt + 1'b1;
            tim_d.sync = (tim_q.cnt < SYNC_LAST);
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign sync   = tim_q.sync;
    assign active = tim_q.active;

    // R1
    frame_wrap_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (frame_end && !pwr_down) |=> (sync && active && tim_q.cnt == '0));

    // R1
    sync_len_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (active && $fell(sync)) |-> (tim_q.cnt == CNT_W'(TAG_W)));

    // R10
    link_idle_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pwr_down |=> (!sync && !active));

endmodule

// File: rtl/aclink_tx.sv
`timescale 1ns/1ps
module aclink_tx #(
    parameter int TAG_W  = aclink_pkg::TAG_BITS,
    parameter int SLOT_W = aclink_pkg::SLOT_BITS,
    parameter int NSLOT  = aclink_pkg::DATA_SLOTS,
    parameter int ADDR_W = aclink_pkg::CMD_ADDR_BITS,
    parameter int DATA_W = aclink_pkg::CMD_DATA_BITS
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              load,
    input  logic              vra_en,
    input  logic              req_l,
    input  logic              req_r,
    input  logic              cmd_valid,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              play_l_valid,
    input  logic [SLOT_W-1:0] play_l,
    input  logic              play_r_valid,
    input  logic [SLOT_W-1:0] play_r,
    output logic              sdata_out,
    output logic              cmd_taken,
    output logic              play_l_taken,
    output logic              play_r_taken
);
    import aclink_pkg::*;

    localparam int FRAME_W = frame_len(TAG_W, SLOT_W, NSLOT);
    localparam int S1_TOP  = slot_top(TAG_W, SLOT_W, NSLOT, 1);
    localparam int S2_TOP  = slot_top(TAG_W, SLOT_W, NSLOT, 2);
    localparam int S3_TOP  = slot_top(TAG_W, SLOT_W, NSLOT, 3);
    localparam int S4_TOP  = slot_top(TAG_W, SLOT_W, NSLOT, 4);
    localparam int CMD_PAD = SLOT_W - 1 - ADDR_W;
    localparam int DAT_PAD = SLOT_W - DATA_W;

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic               cmd_t;
        logic               l_t;
        logic               r_t;
    } tx_t;

    tx_t tx_d, tx_q;

    logic               send_cmd, send_wr, send_l, send_r;
    logic [TAG_W-1:0]   tag;
    logic [FRAME_W-1:0] frame;

    always_comb begin
        send_cmd = cmd_valid;
        send_wr  = cmd_valid && !cmd_rd;
        send_l   = play_l_valid && (!vra_en || req_l);
        send_r   = play_r_valid && (!vra_en || req_r);

        tag = '0;
        tag[tag_pos(TAG_W, 0)] = send_cmd || send_l || send_r;
        tag[tag_pos(TAG_W, 1)] = send_cmd;
        tag[tag_pos(TAG_W, 2)] = send_wr;
        tag[tag_pos(TAG_W, 3)] = send_l;
        tag[tag_pos(TAG_W, 4)] = send_r;

        frame = '0;
        frame[FRAME_W-1 -: TAG_W] = tag;
        if (send_cmd) frame[S1_TOP -: SLOT_W] = SLOT_W'({cmd_rd, cmd_addr}) << CMD_PAD;
        if (send_wr)  frame[S2_TOP -: SLOT_W] = SLOT_W'(cmd_data) << DAT_PAD;
        if (send_l)   frame[S3_TOP -: SLOT_W] = play_l;
        if (send_r)   frame[S4_TOP -: SLOT_W] = play_r;

        tx_d       = tx_q;
        tx_d.cmd_t = 1'b0;
        tx_d.l_t   = 1'b0;
        tx_d.r_t   = 1'b0;
        if (pwr_down) begin
            tx_d.sh = '0;
        end else if (load) begin
            tx_d.sh    = frame;
            tx_d.cmd_t = send_cmd;
            tx_d.l_t   = send_l;
            tx_d.r_t   = send_r;
        end else begin
            tx_d.sh = tx_q.sh << 1;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign sdata_out    = tx_q.sh[FRAME_W-1];
    assign cmd_taken    = tx_q.cmd_t;
    assign play_l_taken = tx_q.l_t;
    assign play_r_taken = tx_q.r_t;

    // R3
    valid_bit_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (cmd_taken || play_l_taken || play_r_taken) |-> sdata_out);

    // R6
    vra_left_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        play_l_taken |-> (!$past(vra_en) || $past(req_l)));

    // R6
    vra_right_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        play_r_taken |-> (!$past(vra_en) || $past(req_r)));

    // R4
    cmd_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cmd_taken |=> !cmd_taken);

endmodule

// File: rtl/aclink_rx.sv
`timescale 1ns/1ps
module aclink_rx #(
    parameter int TAG_W  = aclink_pkg::TAG_BITS,
    parameter int SLOT_W = aclink_pkg::SLOT_BITS,
    parameter int NSLOT  = aclink_pkg::DATA_SLOTS,
    parameter int ADDR_W = aclink_pkg::CMD_ADDR_BITS,
    parameter int DATA_W = aclink_pkg::CMD_DATA_BITS
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              active,
    input  logic              frame_end,
    input  logic              sdata_in,
    output logic              req_l,
    output logic              req_r,
    output logic              codec_ready,
    output logic              sts_valid,
    output logic [ADDR_W-1:0] sts_addr,
    output logic [DATA_W-1:0] sts_data,
    output logic              rec_l_valid,
    output logic [SLOT_W-1:0] rec_l,
    output logic              rec_r_valid,
    output logic [SLOT_W-1:0] rec_r
);
    import aclink_pkg::*;

    localparam int FRAME_W   = frame_len(TAG_W, SLOT_W, NSLOT);
    localparam int S1_TOP    = slot_top(TAG_W, SLOT_W, NSLOT, 1);
    localparam int S2_TOP    = slot_top(TAG_W, SLOT_W, NSLOT, 2);
    localparam int S3_TOP    = slot_top(TAG_W, SLOT_W, NSLOT, 3);
    localparam int S4_TOP    = slot_top(TAG_W, SLOT_W, NSLOT, 4);
    localparam int REQ_L_BIT = SLOT_W - 2 - ADDR_W;
    localparam int REQ_R_BIT = REQ_L_BIT - 1;

    typedef struct packed {
        logic [FRAME_W-2:0] sh;
        logic               ready;
        logic               sts_v;
        logic [ADDR_W-1:0]  sts_a;
        logic [DATA_W-1:0]  sts_d;
        logic               rl_v;
        logic [SLOT_W-1:0]  rl;
        logic               rr_v;
        logic [SLOT_W-1:0]  rr;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic din_neg_q;

    logic [FRAME_W-1:0] full;
    logic [TAG_W-1:0]   tag;
    logic [SLOT_W-1:0]  s1, s2, s3, s4;

    // capture on the falling edge, half a bit time after the codec launched it
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) din_neg_q <= 1'b0;
        else        din_neg_q <= sdata_in;
    end

    always_comb begin
        full = {rx_q.sh, din_neg_q};
        tag  = full[FRAME_W-1 -: TAG_W];
        s1   = full[S1_TOP -: SLOT_W];
        s2   = full[S2_TOP -: SLOT_W];
        s3   = full[S3_TOP -: SLOT_W];
        s4   = full[S4_TOP -: SLOT_W];

        req_l = frame_end && !pwr_down && s1[REQ_L_BIT];
        req_r = frame_end && !pwr_down && s1[REQ_R_BIT];

        rx_d       = rx_q;
        rx_d.sts_v = 1'b0;
        rx_d.rl_v  = 1'b0;
        rx_d.rr_v  = 1'b0;
        if (pwr_down) begin
            rx_d.sh    = '0;
            rx_d.ready = 1'b0;
        end else if (active) begin
            rx_d.sh = full[FRAME_W-2:0];
            if (frame_end) begin
                rx_d.ready = tag[tag_pos(TAG_W, 0)];
                if (tag[tag_pos(TAG_W, 1)] && tag[tag_pos(TAG_W, 2)]) begin
                    rx_d.sts_v = 1'b1;
                    rx_d.sts_a = s1[SLOT_W-2 -: ADDR_W];
                    rx_d.sts_d = s2[SLOT_W-1 -: DATA_W];
                end
                if (tag[tag_pos(TAG_W, 3)]) begin
                    rx_d.rl_v = 1'b1;
                    rx_d.rl   = s3;
                end
                if (tag[tag_pos(TAG_W, 4)]) begin
                    rx_d.rr_v = 1'b1;
                    rx_d.rr   = s4;
                end
            end
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign codec_ready = rx_q.ready;
    assign sts_valid   = rx_q.sts_v;
    assign sts_addr    = rx_q.sts_a;
    assign sts_data    = rx_q.sts_d;
    assign rec_l_valid = rx_q.rl_v;
    assign rec_l       = rx_q.rl;
    assign rec_r_valid = rx_q.rr_v;
    assign rec_r       = rx_q.rr;

    // R8
    sts_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        sts_valid |=> !sts_valid);

    // R9
    rec_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (rec_l_valid || rec_r_valid) |=> (!rec_l_valid && !rec_r_valid));

    // R10
    ready_clear_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pwr_down |=> !codec_ready);

    // R7
    ready_hold_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!$past(frame_end) && !$past(pwr_down)) |-> $stable(codec_ready));

endmodule

// File: rtl/aclink_frame_engine.sv
`timescale 1ns/1ps
module aclink_frame_engine #(
    parameter int TAG_W  = aclink_pkg::TAG_BITS,
    parameter int SLOT_W = aclink_pkg::SLOT_BITS,
    parameter int NSLOT  = aclink_pkg::DATA_SLOTS,
    parameter int ADDR_W = aclink_pkg::CMD_ADDR_BITS,
    parameter int DATA_W = aclink_pkg::CMD_DATA_BITS
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              vra_en,
    input  logic              cmd_valid,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_taken,
    input  logic              play_l_valid,
    input  logic [SLOT_W-1:0] play_l,
    output logic              play_l_taken,
    input  logic              play_r_valid,
    input  logic [SLOT_W-1:0] play_r,
    output logic              play_r_taken,
    output logic              sync,
    output logic              sdata_out,
    input  logic              sdata_in,
    output logic              codec_ready,
    output logic              sts_valid,
    output logic [ADDR_W-1:0] sts_addr,
    output logic [DATA_W-1:0] sts_data,
    output logic              rec_l_valid,
    output logic [SLOT_W-1:0] rec_l,
    output logic              rec_r_valid,
    output logic [SLOT_W-1:0] rec_r
);
    localparam int FRAME_W = aclink_pkg::frame_len(TAG_W, SLOT_W, NSLOT);

    logic active, frame_load, frame_end;
    logic req_l, req_r;

    aclink_timing #(.TAG_W(TAG_W), .FRAME_W(FRAME_W)) i_timing (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .sync       (sync),
        .active     (active),
        .frame_load (frame_load),
        .frame_end  (frame_end)
    );

    aclink_tx #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT),
                .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tx (
        .bit_clk      (bit_clk),
        .rst_n        (rst_n),
        .pwr_down     (pwr_down),
        .load         (frame_load),
        .vra_en       (vra_en),
        .req_l        (req_l),
        .req_r        (req_r),
        .cmd_valid    (cmd_valid),
        .cmd_rd       (cmd_rd),
        .cmd_addr     (cmd_addr),
        .cmd_data     (cmd_data),
        .play_l_valid (play_l_valid),
        .play_l       (play_l),
        .play_r_valid (play_r_valid),
        .play_r       (play_r),
        .sdata_out    (sdata_out),
        .cmd_taken    (cmd_taken),
        .play_l_taken (play_l_taken),
        .play_r_taken (play_r_taken)
    );

    aclink_rx #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT),
                .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rx (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .pwr_down    (pwr_down),
        .active      (active),
        .frame_end   (frame_end),
        .sdata_in    (sdata_in),
        .req_l       (req_l),
        .req_r       (req_r),
        .codec_ready (codec_ready),
        .sts_valid   (sts_valid),
        .sts_addr    (sts_addr),
        .sts_data    (sts_data),
        .rec_l_valid (rec_l_valid),
        .rec_l       (rec_l),
        .rec_r_valid (rec_r_valid),
        .rec_r       (rec_r)
    );

    // R11
    quiet_reset_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(sync) |-> active);

endmodule

// File: tb/test_aclink_frame_engine.sv
`timescale 1ns/1ps
module test_aclink_frame_engine;

    typedef struct packed {
        logic        vra;
        logic        cv;
        logic        crd;
        logic [6:0]  ca;
        logic [15:0] cd;
        logic        lv;
        logic [19:0] ld;
        logic        rv;
        logic [19:0] rd;
        logic        rdy;
        logic        sv;
        logic [6:0]  sa;
        logic [15:0] sd;
        logic        ql;
        logic        qr;
        logic        ilv;
        logic [19:0] il;
        logic        irv;
        logic [19:0] ir;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{vra:1'b0, cv:1'b1, crd:1'b0, ca:7'h02, cd:16'h8A5C, lv:1'b1, ld:20'h12345, rv:1'b1, rd:20'hABCDE,
          rdy:1'b1, sv:1'b0, sa:7'h00, sd:16'h0000, ql:1'b0, qr:1'b0, ilv:1'b1, il:20'h0F0F0, irv:1'b0, ir:20'h13579},
        '{vra:1'b0, cv:1'b1, crd:1'b1, ca:7'h26, cd:16'hFFFF, lv:1'b1, ld:20'h00001, rv:1'b0, rd:20'h99999,
          rdy:1'b1, sv:1'b1, sa:7'h26, sd:16'h000F, ql:1'b1, qr:1'b0, ilv:1'b0, il:20'h2468A, irv:1'b1, ir:20'hFEDCB},
        '{vra:1'b1, cv:1'b0, crd:1'b0, ca:7'h00, cd:16'h0000, lv:1'b1, ld:20'h55555, rv:1'b1, rd:20'hAAAAA,
          rdy:1'b1, sv:1'b0, sa:7'h11, sd:16'h1111, ql:1'b0, qr:1'b1, ilv:1'b1, il:20'h80001, irv:1'b1, ir:20'h7FFFE},
        '{vra:1'b1, cv:1'b1, crd:1'b0, ca:7'h2C, cd:16'h5622, lv:1'b1, ld:20'h11111, rv:1'b1, rd:20'h22222,
          rdy:1'b0, sv:1'b1, sa:7'h7F, sd:16'hFFFF, ql:1'b1, qr:1'b1, ilv:1'b0, il:20'h00000, irv:1'b0, ir:20'h00000},
        '{vra:1'b1, cv:1'b0, crd:1'b0, ca:7'h00, cd:16'h0000, lv:1'b1, ld:20'h33333, rv:1'b1, rd:20'h44444,
          rdy:1'b1, sv:1'b0, sa:7'h00, sd:16'h0000, ql:1'b0, qr:1'b0, ilv:1'b0, il:20'hFFFFF, irv:1'b0, ir:20'hFFFFF},
        '{vra:1'b0, cv:1'b0, crd:1'b0, ca:7'h00, cd:16'h0000, lv:1'b0, ld:20'h77777, rv:1'b0, rd:20'h88888,
          rdy:1'b1, sv:1'b0, sa:7'h00, sd:16'h0000, ql:1'b0, qr:1'b0, ilv:1'b0, il:20'h00000, irv:1'b0, ir:20'h00000}
    };

    logic        bit_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        vra_en = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_rd = 1'b0;
    logic [6:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        cmd_taken;
    logic        play_l_valid = 1'b0;
    logic [19:0] play_l = '0;
    logic        play_l_taken;
    logic        play_r_valid = 1'b0;
    logic [19:0] play_r = '0;
    logic        play_r_taken;
    logic        sync;
    logic        sdata_out;
    logic        sdata_in = 1'b0;
    logic        codec_ready;
    logic        sts_valid;
    logic [6:0]  sts_addr;
    logic [15:0] sts_data;
    logic        rec_l_valid;
    logic [19:0] rec_l;
    logic        rec_r_valid;
    logic [19:0] rec_r;

    int  n_chk = 0;
    int  n_fail = 0;
    logic pl_prev = 1'b0;
    logic pr_prev = 1'b0;

    always #2.5 bit_clk = ~bit_clk;

    aclink_frame_engine i_aclink_frame_engine (
        .bit_clk(bit_clk), .rst_n(rst_n), .pwr_down(pwr_down), .vra_en(vra_en),
        .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_taken(cmd_taken),
        .play_l_valid(play_l_valid), .play_l(play_l), .play_l_taken(play_l_taken),
        .play_r_valid(play_r_valid), .play_r(play_r), .play_r_taken(play_r_taken),
        .sync(sync), .sdata_out(sdata_out), .sdata_in(sdata_in),
        .codec_ready(codec_ready), .sts_valid(sts_valid), .sts_addr(sts_addr), .sts_data(sts_data),
        .rec_l_valid(rec_l_valid), .rec_l(rec_l), .rec_r_valid(rec_r_valid), .rec_r(rec_r)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic apply(input vec_t v);
        vra_en = v.vra; cmd_valid = v.cv; cmd_rd = v.crd; cmd_addr = v.ca; cmd_data = v.cd;
        play_l_valid = v.lv; play_l = v.ld; play_r_valid = v.rv; play_r = v.rd;
    endtask

    // expected outgoing frame, bit 255 first on the wire (R3, R4, R5, R6)
    function automatic logic [255:0] mk_out(input vec_t v, input logic pl, input logic pr);
        logic [255:0] f = '0;
        logic sc = v.cv;
        logic sw = v.cv && !v.crd;
        logic sl = v.lv && (!v.vra || pl);
        logic sr = v.rv && (!v.vra || pr);
        f[255] = sc | sl | sr;
        f[254] = sc; f[253] = sw; f[252] = sl; f[251] = sr;
        if (sc) f[239:220] = {v.crd, v.ca, 12'h000};
        if (sw) f[219:200] = {v.cd, 4'h0};
        if (sl) f[199:180] = v.ld;
        if (sr) f[179:160] = v.rd;
        return f;
    endfunction

    // incoming codec frame; slot 3/4 carry data even when untagged
    function automatic logic [255:0] mk_in(input vec_t v);
        logic [255:0] f = '0;
        f[255] = v.rdy; f[254] = v.sv; f[253] = v.sv; f[252] = v.ilv; f[251] = v.irv;
        if (v.sv) f[238:232] = v.sa;
        f[231] = v.ql;
        f[230] = v.qr;
        if (v.sv) f[219:204] = v.sd;
        f[199:180] = v.il;
        f[179:160] = v.ir;
        return f;
    endfunction

    task automatic run_frame(input int k);
        vec_t v = VECS[k];
        logic [255:0] expo = mk_out(v, pl_prev, pr_prev);
        logic [255:0] inf = mk_in(v);
        logic [255:0] cap = '0;
        bit sync_ok = 1'b1;
        string pt = v.vra ? "R6" : "R5";
        for (int i = 0; i < 256; i++) begin
            cap[255-i] = sdata_out;
            if (sync !== (i < 16)) sync_ok = 1'b0;
            if (i == 0) begin
                chk(cmd_taken === v.cv, "R4 cmd_taken", cmd_taken, v.cv);
                chk(play_l_taken === expo[252], {pt, " play_l_taken"}, play_l_taken, expo[252]);
                chk(play_r_taken === expo[251], {pt, " play_r_taken"}, play_r_taken, expo[251]);
            end
            sdata_in = inf[255-i];
            if (i == 128) begin
                if (k + 1 < NV) apply(VECS[k+1]);
                else            apply(VECS[NV-1]);
            end
            @(negedge bit_clk);
            #1 sdata_in = ~inf[255-i];   // R2: corrupt after the capture edge
            @(posedge bit_clk);
            #1;
        end
        chk(sync_ok, "R1 sync window", sync_ok, 1);
        chk(cap === expo, "R3 outgoing frame", cap, expo);
        chk(codec_ready === v.rdy, "R7 codec_ready", codec_ready, v.rdy);
        chk(sts_valid === v.sv, "R8 sts_valid", sts_valid, v.sv);
        if (v.sv) chk({sts_addr, sts_data} === {v.sa, v.sd}, "R8 status word",
                      {sts_addr, sts_data}, {v.sa, v.sd});
        chk(rec_l_valid === v.ilv, "R9 rec_l_valid", rec_l_valid, v.ilv);
        chk(rec_r_valid === v.irv, "R9 rec_r_valid", rec_r_valid, v.irv);
        if (v.ilv) chk(rec_l === v.il, "R2 R9 rec_l", rec_l, v.il);
        if (v.irv) chk(rec_r === v.ir, "R2 R9 rec_r", rec_r, v.ir);
        pl_prev = v.ql;
        pr_prev = v.qr;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [15:0] tagcap;
        bit quiet;
        apply(VECS[0]);
        repeat (3) @(posedge bit_clk);
        #1;
        // R11
        chk({sync, sdata_out, codec_ready, cmd_taken, play_l_taken, sts_valid, rec_l_valid} === 7'b0,
            "R11 reset outputs", {sync, sdata_out, codec_ready, cmd_taken, play_l_taken, sts_valid, rec_l_valid}, 0);
        rst_n = 1'b1;
        @(posedge bit_clk);
        #1;
        chk(sync === 1'b1, "R1 first frame start", sync, 1);

        for (int k = 0; k < NV; k++) run_frame(k);

        // R10: power-down silences the link
        vra_en = 1'b1; cmd_valid = 1'b1; cmd_rd = 1'b0; play_l_valid = 1'b1; play_r_valid = 1'b0;
        sdata_in = 1'b1;
        pwr_down = 1'b1;
        quiet = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(posedge bit_clk);
            #1;
            if (sync || sdata_out || codec_ready || cmd_taken || play_l_taken) quiet = 1'b0;
        end
        chk(quiet, "R10 link held quiet", quiet, 1);
        sdata_in = 1'b0;
        pwr_down = 1'b0;
        @(posedge bit_clk);
        #1;
        chk(sync === 1'b1, "R10 restart frame", sync, 1);
        chk(cmd_taken === 1'b1, "R10 cmd after restart", cmd_taken, 1);
        chk(play_l_taken === 1'b0, "R6 no sample without request", play_l_taken, 0);
        for (int i = 0; i < 16; i++) begin
            tagcap[15-i] = sdata_out;
            @(posedge bit_clk);
            #1;
        end
        chk(tagcap === 16'hE000, "R3 R10 tag after restart", tagcap, 16'hE000);

        report();
        $finish;
    end

endmodule